// File: doc/BRIEF.md
# Forward Calorimeter Trigger Primitive Builder

This block turns a beat of 48 forward-calorimeter tower energies into 8 coarse trigger primitives. Each primitive is the sum of a 2-wide (phi) by 3-deep (eta) patch of towers. A beat arrives once per bunch crossing, marked by `valid_i`.

Each primitive also carries a shape flag. The flag says that one tower in the patch holds more than a programmable fraction of the patch total. The fraction is an 8-bit value `frac_i`, read as a count of 1/256ths. The block tests it with a multiply and a compare, with no divider. Downstream jet logic can use the flag to tell narrow, concentrated deposits from broad ones.

The results appear on registered outputs exactly two cycles after the input beat. A beat can be accepted on every cycle.

Top module: `ftp_builder`

## Requirements
- R1: Tower input index i (field `tower_i[8i+7:8i]`) sits at phi row i/12 and eta column i%12. Primitive k (field `sum_o[11k+10:11k]`, flag `feat_o[k]`) sums the towers with phi rows 2*(k/4) and 2*(k/4)+1 and eta columns 3*(k%4) to 3*(k%4)+2.
- R2: Sums are unsigned and 11 bits wide. They never wrap: all towers at 255 gives 1530 for every primitive.
- R3: `feat_o[k]` is 1 exactly when some member tower t satisfies t*256 > frac*sum, with a strict compare. Equality gives 0.
- R4: A primitive whose sum is 0 has its flag at 0 for any `frac_i`, including 0.
- R5: `valid_o` is high in the cycle two clock edges after a cycle with `valid_i` high, and only then.
- R6: The fraction used for a beat is the `frac_i` present with that beat. A later change of `frac_i` has no effect on that beat's flags.
- R7: While `valid_o` is low, `sum_o` and `feat_o` keep the last valid result.
- R8: Synchronous active-low reset clears `valid_o`, `sum_o` and `feat_o` to 0.
- R9: Beats on consecutive cycles each produce their own correct result, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Input beat present |
| tower_i | input | 384 | 48 unsigned 8-bit tower energies, index i at bits 8i+7:8i |
| frac_i | input | 8 | Dominance fraction in units of 1/256 |
| valid_o | output | 1 | Result beat present |
| sum_o | output | 88 | 8 primitive sums, 11 bits each |
| feat_o | output | 8 | Dominant-tower flag per primitive |

## Verification
The hardest case to reach from the ports is the exact compare boundary, where tower*256 equals frac*sum. Random energies almost never land there. Directed beats therefore place two equal towers in one patch with a fraction of exactly one half, and then step the fraction down by one.

The sampling of `frac_i` is tested by changing it in the cycle right after a beat, while that beat is still inside the pipeline. Long runs of back-to-back beats and of randomly gapped beats are compared cycle by cycle against a behavioural model. That model also tracks the hold value.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    // Maps member m of primitive k onto a flat tower index.
    // Towers are laid out phi-major: index = phi * eta_n + eta.
    // Primitives are ordered eta-group fastest; members are ordered eta fastest.
    function automatic int member_idx(input int k, input int m, input int eta_n,
                                      input int gp, input int ge);
        int eg_n;
        int pg;
        int eg;
        int ph;
        int et;
        eg_n = eta_n / ge;
        pg   = k / eg_n;
        eg   = k % eg_n;
        ph   = m / ge;
        et   = m % ge;
        return (pg * gp + ph) * eta_n + eg * ge + et;
    endfunction

endpackage

// File: rtl/ftp_group.sv
module ftp_group #(
    parameter int TW_W  = 8,
    parameter int GSIZE = 6,
    parameter int SUM_W = 11
) (
    input  logic [GSIZE*TW_W-1:0] mem_i,
    output logic [SUM_W-1:0]      sum_o,
    output logic [TW_W-1:0]       max_o
);

    // Sum and largest member of one patch.
    always_comb begin
        sum_o = '0;
        max_o = '0;
        for (int m = 0; m < GSIZE; m++) begin
            sum_o = sum_o + SUM_W'(mem_i[m*TW_W +: TW_W]);
            if (mem_i[m*TW_W +: TW_W] > max_o) begin
                max_o = mem_i[m*TW_W +: TW_W];
            end
        end
    end

endmodule

// File: rtl/ftp_flag.sv
module ftp_flag #(
    parameter int TW_W   = 8,
    parameter int SUM_W  = 11,
    parameter int FRAC_W = 8
) (
    input  logic [TW_W-1:0]   max_i,
    input  logic [SUM_W-1:0]  sum_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              flag_o
);

    localparam int PW = FRAC_W + SUM_W;

    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    // If the largest member passes the test, some member does.
    always_comb begin
        lhs    = PW'({max_i, {FRAC_W{1'b0}}});
        rhs    = PW'(frac_i) * PW'(sum_i);
        flag_o = (sum_i != '0) && (lhs > rhs);
    end

endmodule

// File: rtl/ftp_builder.sv
module ftp_builder #(
    parameter  int TW_W    = 8,
    parameter  int PHI_N   = 4,
    parameter  int ETA_N   = 12,
    parameter  int GRP_PHI = 2,
    parameter  int GRP_ETA = 3,
    parameter  int FRAC_W  = 8,
    localparam int NTOW    = PHI_N * ETA_N,
    localparam int GPER    = GRP_PHI * GRP_ETA,
    localparam int NGRP    = NTOW / GPER,
    localparam int SUM_W   = TW_W + $clog2(GPER)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [NTOW*TW_W-1:0]   tower_i,
    input  logic [FRAC_W-1:0]      frac_i,
    output logic                   valid_o,
    output logic [NGRP*SUM_W-1:0]  sum_o,
    output logic [NGRP-1:0]        feat_o
);

    typedef struct packed {
        logic                        vld;
        logic [NGRP-1:0][SUM_W-1:0]  sum;
        logic [NGRP-1:0][TW_W-1:0]   mx;
        logic [FRAC_W-1:0]           frac;
    } s1_t;

    typedef struct packed {
        logic                        vld;
        logic [NGRP-1:0][SUM_W-1:0]  sum;
        logic [NGRP-1:0]             feat;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic [NGRP-1:0][SUM_W-1:0] g_sum;
    logic [NGRP-1:0][TW_W-1:0]  g_max;
    logic [NGRP-1:0]            g_flag;

    for (genvar k = 0; k < NGRP; k++) begin : g_prim
        logic [GPER*TW_W-1:0] members;

        for (genvar m = 0; m < GPER; m++) begin : g_mem
            localparam int SRC = ftp_pkg::member_idx(k, m, ETA_N, GRP_PHI, GRP_ETA);
            assign members[m*TW_W +: TW_W] = tower_i[SRC*TW_W +: TW_W];
        end

        ftp_group #(
            .TW_W  (TW_W),
            .GSIZE (GPER),
            .SUM_W (SUM_W)
        ) u_grp (
            .mem_i (members),
            .sum_o (g_sum[k]),
            .max_o (g_max[k])
        );

        ftp_flag #(
            .TW_W   (TW_W),
            .SUM_W  (SUM_W),
            .FRAC_W (FRAC_W)
        ) u_flag (
            .max_i  (st_q.s1.mx[k]),
            .sum_i  (st_q.s1.sum[k]),
            .frac_i (st_q.s1.frac),
            .flag_o (g_flag[k])
        );
    end

    // Stage 1 holds sums, maxima and the beat's fraction.
    // Stage 2 holds the sums and flags that are output.
    always_comb begin
        st_d        = st_q;
        st_d.s1.vld = valid_i;
        if (valid_i) begin
            st_d.s1.sum  = g_sum;
            st_d.s1.mx   = g_max;
            st_d.s1.frac = frac_i;
        end
        st_d.s2.vld = st_q.s1.vld;
        if (st_q.s1.vld) begin
            st_d.s2.sum  = st_q.s1.sum;
            st_d.s2.feat = g_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.s2.vld;
    assign sum_o   = st_q.s2.sum;
    assign feat_o  = st_q.s2.feat;

endmodule

// File: rtl/ftp_builder_chk.sv
module ftp_builder_chk #(
    parameter int NGRP  = 8,
    parameter int SUM_W = 11,
    parameter int TW_W  = 8,
    parameter int GPER  = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  valid_i,
    input logic                  valid_o,
    input logic [NGRP*SUM_W-1:0] sum_o,
    input logic [NGRP-1:0]       feat_o
);

    localparam int MAXS = GPER * ((1 << TW_W) - 1);

    // R5
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> ##2 valid_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(sum_o) && $stable(feat_o)));

    // R8
    rst_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && sum_o == '0 && feat_o == '0));

    for (genvar k = 0; k < NGRP; k++) begin : g_k
        // R4
        zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            feat_o[k] |-> (sum_o[k*SUM_W +: SUM_W] != '0));

        // R2
        range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sum_o[k*SUM_W +: SUM_W] <= SUM_W'(MAXS));
    end

endmodule

bind ftp_builder ftp_builder_chk #(
    .NGRP  (NGRP),
    .SUM_W (SUM_W),
    .TW_W  (TW_W),
    .GPER  (GPER)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .valid_o (valid_o),
    .sum_o   (sum_o),
    .feat_o  (feat_o)
);

// File: tb/sim_ftp_builder.sv
module sim_ftp_builder;

    localparam int NT = 48;
    localparam int NG = 8;
    localparam int SW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [NT*8-1:0] tower_i = '0;
    logic [7:0]    frac_i = '0;
    logic          valid_o;
    logic [NG*SW-1:0] sum_o;
    logic [NG-1:0] feat_o;

    always #2 clk = ~clk;

    ftp_builder u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .tower_i (tower_i),
        .frac_i  (frac_i),
        .valid_o (valid_o),
        .sum_o   (sum_o),
        .feat_o  (feat_o)
    );

    typedef struct {
        bit              v;
        logic [NG*SW-1:0] s;
        logic [NG-1:0]   f;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   nxt_tw[NT];
    int   nxt_frac = 0;
    logic [NG*SW-1:0] hold_s = '0;
    logic [NG-1:0]    hold_f = '0;

    // Behavioural model built straight from the index rule of R1 and the rule of R3.
    function automatic exp_t model(input bit v, input string tag);
        exp_t e;
        e.v = v; e.tag = tag; e.s = '0; e.f = '0;
        for (int k = 0; k < NG; k++) begin
            int sum = 0;
            bit hit = 0;
            for (int ph = 0; ph < 2; ph++)
                for (int et = 0; et < 3; et++)
                    sum += nxt_tw[(2*(k/4) + ph)*12 + 3*(k%4) + et];
            for (int ph = 0; ph < 2; ph++)
                for (int et = 0; et < 3; et++)
                    if (nxt_tw[(2*(k/4) + ph)*12 + 3*(k%4) + et] * 256 > nxt_frac * sum)
                        hit = 1;
            e.s[k*SW +: SW] = SW'(sum);
            e.f[k] = (sum != 0) && hit;
        end
        return e;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [NG*SW-1:0] act, input logic [NG*SW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: compare outputs against the beat from two cycles back, then drive a new beat.
    task automatic step(input bit v, input string tag);
        @(negedge clk);
        if (q.size() == 2) begin
            exp_t e = q.pop_front();
            if (e.v) begin
                hold_s = e.s;
                hold_f = e.f;
            end
            check(e.v ? e.tag : "R5", "valid_o", {87'b0, valid_o}, {87'b0, e.v});
            check(e.v ? e.tag : "R7", "sum_o", sum_o, hold_s);
            check(e.v ? (e.tag == "R1" ? "R3" : e.tag) : "R7", "feat_o",
                  {80'b0, feat_o}, {80'b0, hold_f});
        end
        valid_i = v;
        frac_i  = 8'(nxt_frac);
        for (int i = 0; i < NT; i++) tower_i[i*8 +: 8] = 8'(nxt_tw[i]);
        q.push_back(model(v, tag));
    endtask

    task automatic clear_tw();
        for (int i = 0; i < NT; i++) nxt_tw[i] = 0;
    endtask

    initial begin
        exp_t idle;
        idle.v = 0; idle.s = '0; idle.f = '0; idle.tag = "R8";
        clear_tw();
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "valid_o", {87'b0, valid_o}, '0);
        check("R8", "sum_o", sum_o, '0);
        check("R8", "feat_o", {80'b0, feat_o}, '0);
        rst_n = 1'b1;
        q.push_back(idle);
        q.push_back(idle);

        // R1: each tower distinct so a wrong index shows in the sum
        for (int i = 0; i < NT; i++) nxt_tw[i] = i + 1;
        nxt_frac = 200;
        step(1, "R1");
        nxt_frac = 60;
        step(1, "R1");

        // R2: full scale sums without wrap
        for (int i = 0; i < NT; i++) nxt_tw[i] = 255;
        nxt_frac = 0;
        step(1, "R2");
        nxt_frac = 255;
        step(1, "R2");

        // R3: exact boundary, two towers of 128 in primitive 0, one of 200 alone in primitive 5
        clear_tw();
        nxt_tw[0] = 128; nxt_tw[1] = 128; nxt_tw[27] = 200;
        nxt_frac = 128;
        step(1, "R3");
        nxt_frac = 127;
        step(1, "R3");
        nxt_frac = 255;
        step(1, "R3");

        // R4: zero sums with a zero fraction
        clear_tw();
        nxt_frac = 0;
        step(1, "R4");

        // R6: change the fraction right after a boundary beat
        nxt_tw[0] = 128; nxt_tw[1] = 128;
        nxt_frac = 128;
        step(1, "R6");
        nxt_frac = 0;
        step(0, "R6");
        step(0, "R6");
        step(0, "R7");

        // R9: back-to-back random beats
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NT; i++)
                nxt_tw[i] = ($urandom_range(3) == 0) ? 0 : int'($urandom_range(255));
            nxt_frac = $urandom_range(255);
            step(1, "R9");
        end

        // R7: gapped random beats, outputs must hold between results
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NT; i++)
                nxt_tw[i] = ($urandom_range(1) == 0) ? 0 : int'($urandom_range(255));
            nxt_frac = $urandom_range(255);
            step(bit'($urandom_range(1)), "R7");
        end

        clear_tw();
        repeat (3) step(0, "R7");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule